// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register core of a small general-purpose I/O port, four pins wide by default. A bus-side controller delivers byte writes and read strobes together with a command index that picks one register. Each pin has a direction bit, an output bit and a polarity-inversion bit. The block turns these into a separate output-enable and output-data signal per pin, so tri-state control stays outside the block. Pin levels are sampled into an input register when that register is read. The sampled value is then presented with the polarity mask applied.

All registers are one byte wide. Only the low bits drive pins. The upper bits of the direction, output and polarity registers are plain storage that software can write and read back. Reads are registered: the byte for a read strobe appears on `rd_data` one clock later and stays there until the next read strobe.

Top module: `gpiox_port_bank`

## Requirements
- R1: After reset, direction reads 0xFF, output reads 0xFF and polarity reads 0x00. Every `pin_oe` bit is 0, every `pin_out` bit is 0, and `rd_data` is 0x00.
- R2: A write with command 3 loads the direction register. From the next clock, `pin_oe[i]` equals the inverse of direction bit i: 0 means output, 1 means input.
- R3: Direction bits 7..4 control no pin, yet they store whatever value is written and read back unchanged.
- R4: A write with command 1 loads the output register. A pin whose `pin_oe` is 1 drives `pin_out[i]` equal to output bit i, and a pin whose `pin_oe` is 0 holds `pin_out[i]` at 0.
- R5: A read strobe with command 0 returns, one clock later, the pins sampled at that strobe, zero-extended to a byte and XORed bitwise with the full polarity register (command 2). Polarity bits 7..4 therefore appear in the upper nibble.
- R6: The input register and `rd_data` change only on a read strobe. Pin changes between read strobes leave `rd_data` unchanged.
- R7: A write with command 0 changes no register. Each write with command 1, 2 or 3 changes only its own register.
- R8: A read with any command above 3 returns 0x00.
- R9: A read with command 1, 2 or 3 returns, one clock later, the value last written to that register, or its reset value if it has not been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| cmd | input | 8 | Register select: 0 input, 1 output, 2 polarity, 3 direction |
| wr_stb | input | 1 | Write pulse: loads `wr_data` into the selected register |
| wr_data | input | 8 | Write byte |
| rd_stb | input | 1 | Read pulse: registers the selected value onto `rd_data` |
| rd_data | output | 8 | Read byte, valid from the clock after `rd_stb` |
| pin_in | input | 4 | Pin levels |
| pin_oe | output | 4 | Per-pin output enable, 1 = drive |
| pin_out | output | 4 | Per-pin drive value |

## Verification
The bench reads the input register with the pins in one pattern, then changes the pins with no read strobe. A design that samples the pins continuously would show the new pattern on `rd_data` without a strobe. The polarity mask is set with nonzero upper bits to catch a design that masks only the pin nibble. The direction register gets mixed upper and lower nibbles, which exposes a design that truncates the unused bits or inverts the enable sense. A write to command 0, and reads above index 3, are checked by reading every register back; a decoder that aliases indices would corrupt a neighbour or return stale data. A second reset in mid-run must restore every default.

// File: rtl/gpiox_pkg.sv
package gpiox_pkg;
   // command indices (bank decode order is behaviour)
   localparam int unsigned IDX_INPUT    = 0;
   localparam int unsigned IDX_OUTPUT   = 1;
   localparam int unsigned IDX_POLARITY = 2;
   localparam int unsigned IDX_DIR      = 3;
   localparam int unsigned IDX_LAST     = 3;

   typedef enum logic [1:0] {
      SEL_INPUT    = 2'd0,
      SEL_OUTPUT   = 2'd1,
      SEL_POLARITY = 2'd2,
      SEL_DIR      = 2'd3
   } bank_sel_e;
endpackage

// File: rtl/gpiox_reg_byte.sv
module gpiox_reg_byte #(
   parameter int unsigned      W   = 8,
   parameter logic [W-1:0]     RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (W > 0) else $error("gpiox_reg_byte: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/gpiox_pin_drive.sv
module gpiox_pin_drive #(
   parameter int unsigned NPINS    = 4,
   parameter bit          GATE_OUT = 1'b1
) (
   input  logic [NPINS-1:0] dir_bits,
   input  logic [NPINS-1:0] out_bits,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pin_out
);
   initial begin
      assert (NPINS > 0) else $error("gpiox_pin_drive: NPINS must be positive");
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pin_oe[i] = ~dir_bits[i];
      if (GATE_OUT) begin : g_gated
         assign pin_out[i] = out_bits[i] & ~dir_bits[i];
      end else begin : g_raw
         assign pin_out[i] = out_bits[i];
      end
   end
endmodule

// File: rtl/gpiox_read_path.sv
module gpiox_read_path
   import gpiox_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned NPINS = 4,
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic [IDX_W-1:0] cmd,
   input  logic [NPINS-1:0] pin_in,
   input  logic [DW-1:0]    out_q,
   input  logic [DW-1:0]    pol_q,
   input  logic [DW-1:0]    dir_q,
   output logic [DW-1:0]    rd_data
);
   localparam logic [DW-1:0] PAD = '0;

   logic [NPINS-1:0] in_q;
   logic [DW-1:0]    in_view;
   logic [DW-1:0]    sel_val;
   logic             idx_ok;
   bank_sel_e        sel;

   initial begin
      assert (NPINS <= DW) else $error("gpiox_read_path: NPINS exceeds DW");
   end

   // input register: loaded only by a read pulse of index 0
   always_ff @(posedge clk) begin
      if (!rst_n)
         in_q <= '0;
      else if (rd_stb && cmd == IDX_W'(IDX_INPUT))
         in_q <= pin_in;
   end

   always_comb begin
      idx_ok = (cmd <= IDX_W'(IDX_LAST));
      sel    = bank_sel_e'(cmd[1:0]);
      in_view = PAD;
      in_view[NPINS-1:0] = pin_in;
      in_view = in_view ^ pol_q;
      sel_val = '0;
      if (idx_ok) begin
         unique case (sel)
            SEL_INPUT:    sel_val = in_view;
            SEL_OUTPUT:   sel_val = out_q;
            SEL_POLARITY: sel_val = pol_q;
            SEL_DIR:      sel_val = dir_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_stb) rd_data <= sel_val;
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data)); // R6
   AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(in_q)); // R6
   AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cmd > IDX_W'(IDX_LAST)) |=> rd_data == '0); // R8
   AST_INPUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cmd == IDX_W'(IDX_INPUT)) |=>
         rd_data[NPINS-1:0] == (in_q ^ $past(pol_q[NPINS-1:0]))); // R5
endmodule

// File: rtl/gpiox_port_bank.sv
module gpiox_port_bank
   import gpiox_pkg::*;
#(
   parameter int unsigned  DW       = 8,
   parameter int unsigned  NPINS    = 4,
   parameter int unsigned  IDX_W    = 8,
   parameter bit           GATE_OUT = 1'b1,
   parameter logic [DW-1:0] OUT_RST = '1,
   parameter logic [DW-1:0] POL_RST = '0,
   parameter logic [DW-1:0] DIR_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] cmd,
   input  logic             wr_stb,
   input  logic [DW-1:0]    wr_data,
   input  logic             rd_stb,
   output logic [DW-1:0]    rd_data,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pin_out
);
   localparam int unsigned NREG = 3;

   logic [NREG-1:0] we_vec;
   logic [DW-1:0]   q_vec [NREG];
   logic [DW-1:0]   out_q, pol_q, dir_q;

   initial begin
      assert (IDX_W >= 2)   else $error("gpiox_port_bank: IDX_W below 2");
      assert (NPINS <= DW)  else $error("gpiox_port_bank: NPINS exceeds DW");
   end

   // write decode: slot k serves command k+1; command 0 has no slot
   localparam logic [DW-1:0] RST_TAB [NREG] = '{OUT_RST, POL_RST, DIR_RST};
   for (genvar k = 0; k < NREG; k++) begin : g_reg
      assign we_vec[k] = wr_stb && (cmd == IDX_W'(k + 1));
      gpiox_reg_byte #(.W(DW), .RST(RST_TAB[k])) reg_i (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (we_vec[k]),
         .d    (wr_data),
         .q    (q_vec[k])
      );
   end

   assign out_q = q_vec[IDX_OUTPUT - 1];
   assign pol_q = q_vec[IDX_POLARITY - 1];
   assign dir_q = q_vec[IDX_DIR - 1];

   gpiox_pin_drive #(.NPINS(NPINS), .GATE_OUT(GATE_OUT)) drive_i (
      .dir_bits(dir_q[NPINS-1:0]),
      .out_bits(out_q[NPINS-1:0]),
      .pin_oe  (pin_oe),
      .pin_out (pin_out)
   );

   gpiox_read_path #(.DW(DW), .NPINS(NPINS), .IDX_W(IDX_W)) rd_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_stb (rd_stb),
      .cmd    (cmd),
      .pin_in (pin_in),
      .out_q  (out_q),
      .pol_q  (pol_q),
      .dir_q  (dir_q),
      .rd_data(rd_data)
   );

   AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && cmd == IDX_W'(IDX_DIR)) |=>
         pin_oe == ~$past(wr_data[NPINS-1:0])); // R2
   AST_DIR_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && cmd == IDX_W'(IDX_DIR)) |=> dir_q == $past(wr_data)); // R3
   AST_DRIVE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && cmd == IDX_W'(IDX_OUTPUT)) |=>
         (pin_out & pin_oe) == ($past(wr_data[NPINS-1:0]) & pin_oe)); // R4
   AST_WR0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && cmd == IDX_W'(IDX_INPUT)) |=>
         $stable(out_q) && $stable(pol_q) && $stable(dir_q)); // R7
   AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(out_q) && $stable(pol_q) && $stable(dir_q)); // R7
endmodule

// File: tb/gpiox_port_bank_tb.sv
module gpiox_port_bank_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cmd = '0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] pin_in = '0;
   logic [3:0] pin_oe, pin_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct { logic [7:0] exp; string tag; } item_t;
   item_t sb_q[$];

   always #5 clk = ~clk;

   gpiox_port_bank dut_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_data(rd_data), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per read strobe, after the edge settles
   always @(posedge clk) begin
      if (rd_stb && rst_n) begin
         #2;
         if (sb_q.size() == 0) begin
            check("scoreboard empty", 8'hEE, 8'h00);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, rd_data, it.exp);
         end
      end
   end

   task automatic wr(input logic [7:0] c, input logic [7:0] d);
      @(negedge clk);
      cmd = c; wr_data = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic rd(input logic [7:0] c, input logic [7:0] exp, input string tag);
      @(negedge clk);
      cmd = c; rd_stb = 1'b1;
      sb_q.push_back('{exp, tag});
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #200us;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      check("R1 oe after reset", {4'h0, pin_oe}, 8'h00);
      check("R1 out after reset", {4'h0, pin_out}, 8'h00);
      check("R1 rd_data after reset", rd_data, 8'h00);
      rd(8'd3, 8'hFF, "R1 R9 dir default");
      rd(8'd1, 8'hFF, "R1 R9 output default");
      rd(8'd2, 8'h00, "R1 R9 polarity default");

      pin_in = 4'b1010;
      rd(8'd0, 8'h0A, "R5 input no inversion");
      wr(8'd2, 8'h05);
      rd(8'd0, 8'h0F, "R5 input with low mask");
      wr(8'd2, 8'hF3);
      rd(8'd0, 8'hF9, "R5 input with upper mask");

      // R6: pins change, no strobe
      pin_in = 4'b0101;
      repeat (3) @(negedge clk);
      check("R6 rd_data held without strobe", rd_data, 8'hF9);
      rd(8'd0, 8'hF6, "R6 R5 fresh sample on strobe");

      wr(8'd3, 8'hA3);
      check("R2 oe after dir write", {4'h0, pin_oe}, 8'h0C);
      rd(8'd3, 8'hA3, "R3 upper dir bits stored");

      wr(8'd1, 8'h06);
      check("R4 out gated by oe", {4'h0, pin_out}, 8'h04);
      wr(8'd1, 8'h0F);
      check("R4 out all high", {4'h0, pin_out}, 8'h0C);

      wr(8'd0, 8'h55);
      rd(8'd1, 8'h0F, "R7 output after write to 0");
      rd(8'd2, 8'hF3, "R7 polarity after write to 0");
      rd(8'd3, 8'hA3, "R7 dir after write to 0");
      check("R7 pins after write to 0", {pin_oe, pin_out}, 8'hCC);

      rd(8'd4, 8'h00, "R8 index 4");
      rd(8'hFF, 8'h00, "R8 index 255");
      rd(8'd7, 8'h00, "R8 index 7");

      wr(8'd3, 8'h00);
      check("R2 R4 all outputs", {pin_oe, pin_out}, 8'hFF);
      wr(8'd3, 8'hF0);
      check("R3 upper-only dir leaves pins output", {pin_oe, pin_out}, 8'hFF);
      rd(8'd3, 8'hF0, "R3 dir F0 readback");
      wr(8'd3, 8'h0F);
      check("R2 all inputs", {pin_oe, pin_out}, 8'h00);

      do_reset();
      check("R1 second reset pins", {pin_oe, pin_out}, 8'h00);
      rd(8'd1, 8'hFF, "R1 output restored");
      rd(8'd2, 8'h00, "R1 polarity restored");
      rd(8'd3, 8'hFF, "R1 dir restored");

      repeat (3) @(negedge clk);
      check("scoreboard drained", 8'(sb_q.size()), 8'h00);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule